// File: doc/BRIEF.md
# Parallel flash command engine

This block is the control side of a byte-wide parallel NOR flash with a 19-bit address and an 8-bit data bus. The host drives active-low chip-enable, output-enable and write-enable strobes, which are sampled in the system clock domain. Bus write cycles are fed to an unlock sequencer. The sequencer recognises three commands: a four-cycle byte program, a six-cycle chip erase and a six-cycle boot lockout. An internal cycle counter models the busy time of each operation. While an operation runs, reads return a polling status byte instead of array data.

The storage is a small register array that stands in for the full 512 KB space. Addresses inside the 16 KB boot region fold onto the upper half of the slots. All other addresses fold onto the lower half. A build parameter places the boot region at the bottom of the space (0x00000 to 0x03FFF) or at the top (0x7C000 to 0x7FFFF). Once the boot region is locked, programs aimed at it are dropped and chip erase leaves it intact. The lock can only be cleared by reset.

Top module: `pflash_engine`

## Requirements
- R1: `dout_en` is high exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. While `dout_en` is low, `dout` is 0x00.
- R2: After reset every byte reads 0xFF. A program leaves the byte equal to the old value AND the written value, so a 0 bit never returns to 1 through programming.
- R3: The write cycles 0x05555/0xAA, 0x02AAA/0x55 and 0x05555/0xA0, followed by a write of (address, data), start a program. The block is then busy for `PROG_CYC` clock cycles, counted from the clock edge that ends the fourth write. After that the new byte reads back.
- R4: The six write cycles 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x80, 0x05555/0xAA, 0x02AAA/0x55 and 0x05555/0x10 start a chip erase. The block is busy for `ERASE_CYC` cycles, after which every unlocked byte reads 0xFF.
- R5: While busy, every read returns a status byte. Bit 7 holds the inverse of bit 7 of the byte being programmed, or 0 during an erase. Bits 6..0 are 0.
- R6: A write cycle that does not match the expected step of a sequence returns the sequencer to idle. The following cycles are then decoded as the start of a new sequence.
- R7: A write cycle spans the interval in which both `ce_n` and `we_n` are low. The address is taken when the later of the two strobes falls. The data is the value present when the earlier of the two strobes rises.
- R8: The array holds 2^`MEM_AW` bytes. Boot-region addresses (bits 18..14 all 0 for bottom placement, all 1 for top placement) map to slot {1, addr[MEM_AW-2:0]}. Any other address maps to slot {0, addr[MEM_AW-2:0]}.
- R9: The sequence 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x80, 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x40 sets a lock that only reset clears. After the lock is set, a program to a boot-region address does not start, does not make the block busy and does not change data.
- R10: A chip erase that runs with the lock set leaves every boot-region byte unchanged.
- R11: Write cycles that end while the block is busy are discarded and start no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 19 | Byte address |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data or polling status |
| dout_en | output | 1 | High while the host may take `dout` from the bus |

## Verification
Some internal faults show on the very next read. A sequencer stuck in a partial unlock state lets a stray data write start a program. A busy counter that is off by one moves the edge at which the status byte gives way to real data by one clock. Other faults take longer to surface. A lock flag that is lost, or an erase enable that ignores it, only shows once an erase has completed, when a boot byte reads 0xFF where programmed data should remain. For that reason the bench sweeps every slot before and after each lock and erase step.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  // Unlock sequencer positions
  typedef enum logic [2:0] {
    SQ_IDLE,   // waiting for first unlock write
    SQ_U1,     // first unlock byte seen
    SQ_U2,     // second unlock byte seen, command byte next
    SQ_PDATA,  // program armed, target write next
    SQ_E1,     // extended prefix seen, third unlock next
    SQ_E2,     // third unlock seen
    SQ_E3      // fourth unlock seen, final command next
  } seq_st_t;

  // Operation running in the core
  typedef enum logic [1:0] {
    OPK_NONE,
    OPK_PROG,
    OPK_ERASE
  } op_kind_t;

endpackage

// File: rtl/pflash_bus_capture.sv
// Turns strobe levels into single-cycle write events (R7).
module pflash_bus_capture #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  logic          act;
  logic          act_q;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  // Write window: both strobes low.
  assign act = ~ce_n & ~we_n;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    // Later falling strobe opens the window: take the address once.
    if (act & ~act_q) addr_d = addr;
    // Track data until the earlier rising strobe closes the window.
    if (act) data_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q  <= act;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_evt  = act_q & ~act;
  assign wr_addr = addr_q;
  assign wr_data = data_q;

endmodule

// File: rtl/pflash_cmd_seq.sv
// Unlock sequence decoder (R3, R4, R6, R9, R11).
module pflash_cmd_seq
  import pflash_pkg::*;
#(
  parameter int unsigned   AW        = 19,
  parameter int unsigned   DW        = 8,
  parameter logic [AW-1:0] KEY_A1    = 19'h05555,
  parameter logic [AW-1:0] KEY_A2    = 19'h02AAA,
  parameter logic [DW-1:0] KEY_D1    = 8'hAA,
  parameter logic [DW-1:0] KEY_D2    = 8'h55,
  parameter logic [DW-1:0] OP_PROG   = 8'hA0,
  parameter logic [DW-1:0] OP_EXT    = 8'h80,
  parameter logic [DW-1:0] OP_ERASE  = 8'h10,
  parameter logic [DW-1:0] OP_LOCK   = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          core_busy,
  output logic          prog_go,
  output logic          erase_go,
  output logic          lock_go
);

  seq_st_t st_q, st_d;
  logic    key1, key2, at_a1;

  assign key1  = (wr_addr == KEY_A1) && (wr_data == KEY_D1);
  assign key2  = (wr_addr == KEY_A2) && (wr_data == KEY_D2);
  assign at_a1 = (wr_addr == KEY_A1);

  always_comb begin
    st_d     = st_q;
    prog_go  = 1'b0;
    erase_go = 1'b0;
    lock_go  = 1'b0;
    if (wr_evt) begin
      if (core_busy) begin
        st_d = SQ_IDLE;                 // R11: cycles during busy are dropped
      end else begin
        unique case (st_q)
          SQ_IDLE:  st_d = key1 ? SQ_U1 : SQ_IDLE;
          SQ_U1:    st_d = key2 ? SQ_U2 : SQ_IDLE;   // R6
          SQ_U2: begin
            if (at_a1 && wr_data == OP_PROG)     st_d = SQ_PDATA;
            else if (at_a1 && wr_data == OP_EXT) st_d = SQ_E1;
            else                                 st_d = SQ_IDLE;
          end
          SQ_PDATA: begin
            prog_go = 1'b1;
            st_d    = SQ_IDLE;
          end
          SQ_E1:    st_d = key1 ? SQ_E2 : SQ_IDLE;
          SQ_E2:    st_d = key2 ? SQ_E3 : SQ_IDLE;
          SQ_E3: begin
            st_d     = SQ_IDLE;
            erase_go = at_a1 && (wr_data == OP_ERASE);
            lock_go  = at_a1 && (wr_data == OP_LOCK);
          end
          default:  st_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/pflash_core.sv
// Busy timer, folded array, boot lock and read path (R2..R5, R8..R10).
module pflash_core
  import pflash_pkg::*;
#(
  parameter int unsigned AW        = 19,
  parameter int unsigned DW        = 8,
  parameter int unsigned MEM_AW    = 5,
  parameter int unsigned BOOT_LOG2 = 14,
  parameter bit          BOOT_TOP  = 1'b0,
  parameter int unsigned PROG_CYC  = 16,
  parameter int unsigned ERASE_CYC = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_go,
  input  logic          erase_go,
  input  logic          lock_go,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  input  logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          locked,
  output logic [DW-1:0] rd_data
);

  localparam int unsigned DEPTH   = 1 << MEM_AW;
  localparam int unsigned HALF_AW = MEM_AW - 1;
  localparam int unsigned MAXC    = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned TW      = $clog2(MAXC + 1);

  function automatic logic in_boot(input logic [AW-1:0] a);
    if (BOOT_TOP) return &a[AW-1:BOOT_LOG2];
    else          return ~|a[AW-1:BOOT_LOG2];
  endfunction

  // R8: boot addresses fold to the upper half of the slots
  function automatic logic [MEM_AW-1:0] slot_of(input logic [AW-1:0] a);
    return {in_boot(a), a[HALF_AW-1:0]};
  endfunction

  logic [TW-1:0]     cnt_q, cnt_d;
  op_kind_t          kind_q, kind_d;
  logic [MEM_AW-1:0] idx_q, idx_d;
  logic [DW-1:0]     pat_q, pat_d;
  logic              lock_q, lock_d;
  logic              prog_ok, commit;
  logic [DEPTH-1:0][DW-1:0] cells;

  // R9: a locked boot target never starts
  assign prog_ok = prog_go & ~(lock_q & in_boot(op_addr));
  assign commit  = (cnt_q == TW'(1));

  always_comb begin
    cnt_d  = cnt_q;
    kind_d = kind_q;
    idx_d  = idx_q;
    pat_d  = pat_q;
    lock_d = lock_q | lock_go;          // sticky until reset
    if (cnt_q != '0) begin
      cnt_d = cnt_q - TW'(1);
      if (commit) kind_d = OPK_NONE;
    end else if (prog_ok) begin
      cnt_d  = TW'(PROG_CYC);
      kind_d = OPK_PROG;
      idx_d  = slot_of(op_addr);
      pat_d  = op_data;
    end else if (erase_go) begin
      cnt_d  = TW'(ERASE_CYC);
      kind_d = OPK_ERASE;
      idx_d  = '0;
      pat_d  = '1;                      // status bit 7 reads 0 during erase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      kind_q <= OPK_NONE;
      idx_q  <= '0;
      pat_q  <= '1;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      idx_q  <= idx_d;
      pat_q  <= pat_d;
      lock_q <= lock_d;
    end
  end

  for (genvar j = 0; j < int'(DEPTH); j++) begin : g_slot
    localparam bit IS_BOOT = (j >= int'(DEPTH / 2));
    logic [DW-1:0] cell_q, cell_d;
    logic          hit;

    always_comb begin
      hit = 1'b0;
      if (commit) begin
        if (kind_q == OPK_PROG)       hit = (idx_q == MEM_AW'(j));
        else if (kind_q == OPK_ERASE) hit = ~(IS_BOOT & lock_q);   // R10
      end
      // R2: program only clears bits; erase sets all
      cell_d = (kind_q == OPK_PROG) ? (cell_q & pat_q) : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q <= '1;
      else if (hit) cell_q <= cell_d;
    end

    assign cells[j] = cell_q;
  end

  assign busy    = (cnt_q != '0);
  assign locked  = lock_q;
  // R5: polling byte while busy
  assign rd_data = busy ? {~pat_q[DW-1], {(DW-1){1'b0}}} : cells[slot_of(rd_addr)];

endmodule

// File: rtl/pflash_engine.sv
module pflash_engine #(
  parameter int unsigned   AW        = 19,
  parameter int unsigned   DW        = 8,
  parameter int unsigned   MEM_AW    = 5,
  parameter int unsigned   BOOT_LOG2 = 14,
  parameter bit            BOOT_TOP  = 1'b0,
  parameter int unsigned   PROG_CYC  = 16,
  parameter int unsigned   ERASE_CYC = 48,
  parameter logic [AW-1:0] KEY_A1    = 19'h05555,
  parameter logic [AW-1:0] KEY_A2    = 19'h02AAA,
  parameter logic [DW-1:0] KEY_D1    = 8'hAA,
  parameter logic [DW-1:0] KEY_D2    = 8'h55,
  parameter logic [DW-1:0] OP_PROG   = 8'hA0,
  parameter logic [DW-1:0] OP_EXT    = 8'h80,
  parameter logic [DW-1:0] OP_ERASE  = 8'h10,
  parameter logic [DW-1:0] OP_LOCK   = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en
);

  logic          rst_meta, rst_sync_n;
  logic          wr_evt;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          prog_go, erase_go, lock_go;
  logic          busy, locked;
  logic [DW-1:0] rd_data;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pflash_bus_capture #(.AW(AW), .DW(DW)) u_bus (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .addr    (addr),
    .din     (din),
    .wr_evt  (wr_evt),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  pflash_cmd_seq #(
    .AW(AW), .DW(DW), .KEY_A1(KEY_A1), .KEY_A2(KEY_A2), .KEY_D1(KEY_D1),
    .KEY_D2(KEY_D2), .OP_PROG(OP_PROG), .OP_EXT(OP_EXT),
    .OP_ERASE(OP_ERASE), .OP_LOCK(OP_LOCK)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_evt    (wr_evt),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .core_busy (busy),
    .prog_go   (prog_go),
    .erase_go  (erase_go),
    .lock_go   (lock_go)
  );

  pflash_core #(
    .AW(AW), .DW(DW), .MEM_AW(MEM_AW), .BOOT_LOG2(BOOT_LOG2),
    .BOOT_TOP(BOOT_TOP), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .prog_go  (prog_go),
    .erase_go (erase_go),
    .lock_go  (lock_go),
    .op_addr  (wr_addr),
    .op_data  (wr_data),
    .rd_addr  (addr),
    .busy     (busy),
    .locked   (locked),
    .rd_data  (rd_data)
  );

  // R1: read strobe decode, data forced low when not enabled
  assign dout_en = ~ce_n & ~oe_n & we_n;
  assign dout    = dout_en ? rd_data : '0;

endmodule

// File: rtl/pflash_engine_chk.sv
module pflash_engine_chk #(
  parameter int unsigned DW        = 8,
  parameter int unsigned PROG_CYC  = 16,
  parameter int unsigned ERASE_CYC = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          locked,
  input logic          prog_go,
  input logic          erase_go,
  input logic          lock_go,
  input logic          wr_evt,
  input logic          ce_n,
  input logic          we_n,
  input logic          dout_en,
  input logic [DW-1:0] dout
);

  localparam int unsigned MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned RW   = $clog2(MAXC + 1) + 1;

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + RW'(1);
    else           run_q <= '0;
  end

  // R3 and R4: a busy interval lasts exactly one of the two configured spans
  a_r3_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RW'(PROG_CYC) || run_q == RW'(ERASE_CYC)));

  // R11: no command is issued to the core while it is busy
  a_r11_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(prog_go || erase_go || lock_go));

  // R3: at most one command leaves the sequencer per cycle
  a_r3_one_command: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go, erase_go, lock_go}));

  // R5: low status bits stay zero during a busy read
  a_r5_status_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_en) |-> (dout[DW-2:0] == '0));

  // R9: lock never clears
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R7: a write event only follows the close of the strobe window
  a_r7_event_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> (ce_n || we_n));

endmodule

bind pflash_engine pflash_engine_chk #(
  .DW(DW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .busy     (busy),
  .locked   (locked),
  .prog_go  (prog_go),
  .erase_go (erase_go),
  .lock_go  (lock_go),
  .wr_evt   (wr_evt),
  .ce_n     (ce_n),
  .we_n     (we_n),
  .dout_en  (dout_en),
  .dout     (dout)
);

// File: tb/pflash_engine_test.sv
`timescale 1ns/1ps
module pflash_engine_test;

  localparam int PROG_CYC  = 16;
  localparam int ERASE_CYC = 48;
  localparam logic [18:0] A1 = 19'h05555;
  localparam logic [18:0] A2 = 19'h02AAA;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, oe_n, we_n;
  logic [18:0] addr;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        dout_en;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdl [32];

  always #4 clk = ~clk;

  pflash_engine uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // Slots 0..15 main, 16..31 boot (bottom placement)
  function automatic logic [18:0] slot_a(input int i);
    if (i >= 16) return 19'(i - 16);
    return 19'h10000 + 19'(i);
  endfunction

  function automatic logic [18:0] alias_a(input int i);
    if (i >= 16) return 19'h03FF0 + 19'(i - 16);
    return 19'h7FFF0 + 19'(i);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [18:0] a, output logic [7:0] v);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    #1 v = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; din = 8'h00;
  endtask

  task automatic unlock_ext();
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h80); wr(A1, 8'hAA); wr(A2, 8'h55);
  endtask

  // Full program with status and timing checks
  task automatic prog(input int i, input logic [7:0] d);
    logic [7:0] v;
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'hA0); wr(slot_a(i), d);
    mdl[i] = mdl[i] & d;
    @(posedge clk); @(negedge clk);
    rd(slot_a(i), v); chk("R5 status at start", v, {~d[7], 7'b0});
    repeat (PROG_CYC - 1) @(posedge clk);
    @(negedge clk);
    rd(slot_a(i), v); chk("R3 still busy last cycle", v, {~d[7], 7'b0});
    @(posedge clk); @(negedge clk);
    rd(slot_a(i), v); chk("R2 R3 programmed value", v, mdl[i]);
  endtask

  task automatic erase_chip();
    logic [7:0] v;
    unlock_ext(); wr(A1, 8'h10);
    @(posedge clk); @(negedge clk);
    rd(slot_a(3), v); chk("R5 erase status", v, 8'h00);
    repeat (ERASE_CYC - 1) @(posedge clk);
    @(negedge clk);
    rd(slot_a(3), v); chk("R4 erase still busy", v, 8'h00);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic sweep(input string req);
    logic [7:0] v;
    for (int i = 0; i < 32; i++) begin
      rd(slot_a(i), v); chk(req, v, mdl[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    for (int i = 0; i < 32; i++) mdl[i] = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R2: reset state
    sweep("R2 reset erased");

    // R1: strobe decode, all eight combinations
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      addr = slot_a(5); din = 8'h00;
      ce_n = c[2]; oe_n = c[1]; we_n = c[0];
      #1;
      chk("R1 dout_en", {7'b0, dout_en}, {7'b0, c == 1});
      chk("R1 dout", dout, (c == 1) ? 8'hFF : 8'h00);
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    end

    // R3 R5 R8: program every slot
    for (int i = 0; i < 32; i++) prog(i, 8'(i * 37 + 5));
    // R2: second pass can only clear bits
    for (int i = 0; i < 32; i++) prog(i, 8'(~(i * 11)));
    // R8: aliased addresses reach the same slots
    for (int i = 0; i < 32; i++) begin
      rd(alias_a(i), v); chk("R8 alias", v, mdl[i]);
    end

    // R6: broken sequences
    wr(A1, 8'hAA); wr(A1, 8'h77); wr(slot_a(7), 8'h00);
    @(posedge clk); @(negedge clk);
    rd(slot_a(7), v); chk("R6 bad second byte", v, mdl[7]);
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(19'h01234, 8'hA0); wr(slot_a(8), 8'h00);
    @(posedge clk); @(negedge clk);
    rd(slot_a(8), v); chk("R6 bad command addr", v, mdl[8]);
    repeat (PROG_CYC + 2) @(posedge clk);
    @(negedge clk);
    rd(slot_a(7), v); chk("R6 no late program", v, mdl[7]);
    rd(slot_a(8), v); chk("R6 no late program", v, mdl[8]);

    // R7: staggered strobes on the target cycle
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'hA0);
    @(negedge clk); addr = slot_a(20); din = 8'hFF; we_n = 1'b0; ce_n = 1'b1;
    @(negedge clk); addr = slot_a(5); ce_n = 1'b0;
    @(negedge clk); addr = slot_a(20); din = 8'h0F;
    @(negedge clk); we_n = 1'b1; din = 8'h00;
    @(negedge clk); ce_n = 1'b1;
    mdl[5] = mdl[5] & 8'h0F;
    repeat (PROG_CYC + 2) @(posedge clk);
    @(negedge clk);
    rd(slot_a(5), v);  chk("R7 address and data capture", v, mdl[5]);
    rd(slot_a(20), v); chk("R7 junk address untouched", v, mdl[20]);

    // R11: a second program during busy is dropped
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'hA0); wr(slot_a(9), 8'h00);
    mdl[9] = 8'h00;
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'hA0); wr(slot_a(10), 8'h00);
    repeat (PROG_CYC + 2) @(posedge clk);
    @(negedge clk);
    rd(slot_a(9), v);  chk("R11 first program done", v, mdl[9]);
    rd(slot_a(10), v); chk("R11 busy write ignored", v, mdl[10]);

    // R4: erase without lock
    erase_chip();
    for (int i = 0; i < 32; i++) mdl[i] = 8'hFF;
    sweep("R4 erased");

    // R9: lock the boot region
    for (int i = 16; i < 20; i++) prog(i, 8'(8'h30 + i));
    unlock_ext(); wr(A1, 8'h40);
    @(posedge clk); @(negedge clk);
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'hA0); wr(slot_a(16), 8'h00);
    @(posedge clk); @(negedge clk);
    rd(slot_a(16), v); chk("R9 locked program not busy", v, mdl[16]);
    repeat (PROG_CYC + 2) @(posedge clk);
    @(negedge clk);
    rd(slot_a(16), v); chk("R9 locked data kept", v, mdl[16]);
    prog(2, 8'h81);

    // R10: erase keeps boot slots
    erase_chip();
    for (int i = 0; i < 16; i++) mdl[i] = 8'hFF;
    sweep("R10 erase with lock");
    erase_chip();
    sweep("R9 R10 lock persists");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule